// File: doc/BRIEF.md
# PLCP Path Parity and G1 Status Monitor

This receive-side monitor watches the byte stream of a physical layer convergence frame recovered from a DS3 payload. Strobes from the upstream aligner mark the first byte of each frame, the bytes that carry framing or path identification, the B1 parity byte and the G1 status byte. The block keeps an even-parity BIP-8 over each frame's covered bytes. It checks that parity against the B1 byte that arrives in the next frame and counts how many of the eight bit positions disagree.

Each per-frame disagreement count does two things. It is added to a saturating 16-bit counter that software reads through a byte-wide port, and it is handed to the local transmitter as a 4-bit far-end block error value for its outgoing G1 byte. The remote alarm bit of the incoming G1 byte is filtered over consecutive frames to produce a yellow-alarm status. Finding frame alignment and delineating cells are left to neighbouring blocks. The `sync_i` input reports whether alignment is held.

Top module: `plcp_b1_g1_mon`

## Requirements
- R1: Bytes strobed with `skip_i` (the two framing bytes and the path identifier byte of each row) are left out of the parity. Every other valid byte, including B1 and G1, is XORed into it. `sof_i` marks the first byte of a frame.
- R2: On a B1 byte, the parity of the previous frame is compared with it bit by bit. One cycle after that B1 byte, `febe_vld_o` pulses for one cycle and `febe_o` holds the number of differing bits (0 to 8). The value is meant for bits 7:4 of the transmitted G1.
- R3: No comparison is made (no pulse, no count) for the B1 byte of the first frame after reset, or of the first frame after `sync_i` was low at any time.
- R4: Each comparison adds its differing-bit count to a 16-bit error counter. The counter stops at 0xFFFF and does not wrap.
- R5: While `rd_hi_i` is high, `rd_data_o` shows counter bits 15:8. At that clock edge the counter clears and bits 7:0 are captured into a holding byte.
- R6: While `rd_hi_i` is low, `rd_data_o` shows the holding byte. It is zero after reset.
- R7: When a read with `rd_hi_i` and a comparison fall in the same cycle, the counter takes that comparison's count instead of zero.
- R8: The alarm bit is G1 bit 3, and G1 bits 7:4 and 2:0 have no effect on it. `yellow_o` rises only after 10 consecutive frames with the alarm bit set.
- R9: `yellow_o` falls only after 10 consecutive frames with the alarm bit clear. A frame whose bit matches the current status restarts the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame alignment held |
| data_i | input | 8 | Frame byte |
| data_vld_i | input | 1 | `data_i` carries a byte this cycle |
| sof_i | input | 1 | Byte is the first of a frame |
| skip_i | input | 1 | Byte is excluded from parity |
| b1_i | input | 1 | Byte is the B1 parity byte |
| g1_i | input | 1 | Byte is the G1 status byte |
| rd_hi_i | input | 1 | Read counter high byte, clear counter |
| rd_data_o | output | 8 | Counter high byte or held low byte |
| febe_o | output | 4 | Differing-bit count of the last comparison |
| febe_vld_o | output | 1 | `febe_o` updated this cycle |
| yellow_o | output | 1 | Filtered remote alarm status |

## Verification
The assertions assume that the frame strobes are only meaningful together with `data_vld_i`, and that a B1 byte never shares a cycle with `sof_i`, so that a comparison always uses the parity latched at the start of the current frame. They also assume that `sync_i` stays steady across a frame. The stimulus builds every frame from a fixed order of bytes: three skipped overhead bytes with the start strobe on the first, then B1, then G1, then payload. `sync_i` changes only on the first byte of a frame. Each B1 value is derived from the bench's own parity of the preceding frame XOR a chosen error mask. This also covers zero, single-bit and all-bit errors, saturation, and a read that lands on the B1 cycle.

// File: rtl/plcp_mon_pkg.sv
package plcp_mon_pkg;
  localparam int DATA_W  = 8;
  localparam int CNT_W   = 16;
  localparam int PERSIST = 10;
  localparam int RAI_BIT = 3;
  localparam int FEBE_W  = $clog2(DATA_W + 1);
endpackage

// File: rtl/plcp_bip_chk.sv
module plcp_bip_chk
  import plcp_mon_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int EW = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  logic [W-1:0]  data_i,
  input  logic          vld_i,
  input  logic          sof_i,
  input  logic          skip_i,
  input  logic          b1_i,
  output logic          err_vld_o,
  output logic [EW-1:0] err_cnt_o
);
  logic [W-1:0]  acc_q, prev_q, diff;
  logic          acc_ok_q, have_q;
  logic [EW-1:0] pop;

  assign diff = data_i ^ prev_q;

  always_comb begin
    pop = '0;
    for (int i = 0; i < W; i++) pop = pop + EW'(diff[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      prev_q    <= '0;
      acc_ok_q  <= 1'b0;
      have_q    <= 1'b0;
      err_vld_o <= 1'b0;
      err_cnt_o <= '0;
    end else begin
      if (vld_i && sof_i) begin
        prev_q <= acc_q;
        acc_q  <= skip_i ? '0 : data_i;
      end else if (vld_i && !skip_i) begin
        acc_q  <= acc_q ^ data_i;
      end
      // prior parity is usable only if a whole frame ran under alignment
      if (!sync_i) begin
        acc_ok_q <= 1'b0;
        have_q   <= 1'b0;
      end else if (vld_i && sof_i) begin
        acc_ok_q <= 1'b1;
        have_q   <= acc_ok_q;
      end
      err_vld_o <= vld_i && b1_i && have_q && sync_i;
      err_cnt_o <= pop;
    end
  end

  // R3
  no_first_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && b1_i && !have_q) |=> !err_vld_o);
  // R2
  febe_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_vld_o |-> (err_cnt_o <= EW'(W)));
endmodule

// File: rtl/plcp_err_cnt.sv
module plcp_err_cnt
  import plcp_mon_pkg::*;
#(
  parameter int CW   = CNT_W,
  parameter int IW   = FEBE_W,
  localparam int HALF = CW / 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            inc_vld_i,
  input  logic [IW-1:0]   inc_i,
  input  logic            rd_hi_i,
  output logic [HALF-1:0] rd_data_o
);
  localparam logic [CW-1:0] MAX = {CW{1'b1}};

  logic [CW-1:0]   cnt_q, sat;
  logic [CW:0]     sum;
  logic [HALF-1:0] hold_q;

  assign sum       = {1'b0, cnt_q} + (CW+1)'(inc_i);
  assign sat       = sum[CW] ? MAX : sum[CW-1:0];
  assign rd_data_o = rd_hi_i ? cnt_q[CW-1:HALF] : hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else if (rd_hi_i) begin
      hold_q <= cnt_q[HALF-1:0];
      cnt_q  <= inc_vld_i ? CW'(inc_i) : '0;
    end else if (inc_vld_i) begin
      cnt_q  <= sat;
    end
  end

  // R4
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_vld_i && !rd_hi_i) |=> (cnt_q >= $past(cnt_q)));
  // R4
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && !rd_hi_i) |=> (cnt_q == MAX));
  // R5
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi_i && !inc_vld_i) |=> (cnt_q == '0));
  // R7
  rd_keep_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi_i && inc_vld_i) |=> (cnt_q != '0 || $past(inc_i) == '0));
endmodule

// File: rtl/plcp_rai_filt.sv
module plcp_rai_filt
  import plcp_mon_pkg::*;
#(
  parameter int N  = PERSIST,
  localparam int RW = $clog2(N + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic g1_vld_i,
  input  logic rai_i,
  output logic yellow_o
);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= '0;
      yellow_o <= 1'b0;
    end else if (g1_vld_i) begin
      if (rai_i != yellow_o) begin
        if (run_q == RW'(N - 1)) begin
          yellow_o <= rai_i;
          run_q    <= '0;
        end else begin
          run_q    <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  // R8
  yel_only_on_g1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !g1_vld_i |=> $stable(yellow_o));
  // R9
  run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q < RW'(N));
endmodule

// File: rtl/plcp_b1_g1_mon.sv
module plcp_b1_g1_mon
  import plcp_mon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              data_vld_i,
  input  logic              sof_i,
  input  logic              skip_i,
  input  logic              b1_i,
  input  logic              g1_i,
  input  logic              rd_hi_i,
  output logic [7:0]        rd_data_o,
  output logic [FEBE_W-1:0] febe_o,
  output logic              febe_vld_o,
  output logic              yellow_o
);
  plcp_bip_chk #(.W(DATA_W)) u_bip (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (sync_i),
    .data_i    (data_i),
    .vld_i     (data_vld_i),
    .sof_i     (sof_i),
    .skip_i    (skip_i),
    .b1_i      (b1_i),
    .err_vld_o (febe_vld_o),
    .err_cnt_o (febe_o)
  );

  plcp_err_cnt #(.CW(CNT_W), .IW(FEBE_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_vld_i (febe_vld_o),
    .inc_i     (febe_o),
    .rd_hi_i   (rd_hi_i),
    .rd_data_o (rd_data_o)
  );

  plcp_rai_filt #(.N(PERSIST)) u_rai (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .g1_vld_i (data_vld_i && g1_i),
    .rai_i    (data_i[RAI_BIT]),
    .yellow_o (yellow_o)
  );

  // R1
  no_skip_on_b1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_vld_i && b1_i) |-> !skip_i);
endmodule

// File: tb/plcp_b1_g1_mon_bench.sv
`timescale 1ns/1ps
module plcp_b1_g1_mon_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_ni, sync_i, data_vld_i, sof_i, skip_i, b1_i, g1_i, rd_hi_i;
  logic [7:0] data_i, rd_data_o;
  logic [3:0] febe_o;
  logic       febe_vld_o, yellow_o;

  plcp_b1_g1_mon u_plcp_b1_g1_mon (
    .clk_i(clk), .rst_ni(rst_ni), .sync_i(sync_i), .data_i(data_i),
    .data_vld_i(data_vld_i), .sof_i(sof_i), .skip_i(skip_i), .b1_i(b1_i),
    .g1_i(g1_i), .rd_hi_i(rd_hi_i), .rd_data_o(rd_data_o), .febe_o(febe_o),
    .febe_vld_o(febe_vld_o), .yellow_o(yellow_o)
  );

  int n_chk = 0, n_bad = 0;
  int exp_q[$];
  int exp_cnt = 0, exp_hold = 0, run = 0;
  logic [7:0] prev_bip = '0;
  bit prev_ok = 0, exp_yel = 0, done = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(logic [7:0] d, bit s, bit k, bit b, bit g, bit r, bit sy);
    @(negedge clk);
    data_i = d; data_vld_i = 1'b1; sof_i = s; skip_i = k;
    b1_i = b; g1_i = g; rd_hi_i = r; sync_i = sy;
  endtask

  // R1 R2: bench parity covers B1, G1, payload; the three leading bytes are skipped
  task automatic frame(bit sy, logic [7:0] emask, logic [7:0] g1v, bit rd_b1, logic [7:0] pay);
    bit cmp = sy && prev_ok;
    logic [7:0] b1v = prev_bip ^ emask;
    int pc = $countones(emask);
    drive(8'hF6, 1, 1, 0, 0, 0, sy);
    drive(8'h28, 0, 1, 0, 0, 0, sy);
    drive(pay ^ 8'h3C, 0, 1, 0, 0, 0, sy);
    if (cmp) exp_q.push_back(pc);
    drive(b1v, 0, 0, 1, 0, rd_b1, sy);
    if (rd_b1) begin
      #1 check("R7 high byte on coincident read", rd_data_o, exp_cnt >> 8);
      exp_hold = exp_cnt & 255;
      exp_cnt  = cmp ? pc : 0;
    end else if (cmp) begin
      exp_cnt = (exp_cnt + pc > 65535) ? 65535 : exp_cnt + pc;
    end
    drive(g1v, 0, 0, 0, 1, 0, sy);
    if (g1v[3] != exp_yel) begin
      run++;
      if (run == 10) begin exp_yel = g1v[3]; run = 0; end
    end else run = 0;
    drive(pay, 0, 0, 0, 0, 0, sy);
    prev_bip = b1v ^ g1v ^ pay;
    prev_ok  = sy;
    @(negedge clk);
    data_vld_i = 1'b0; sof_i = 0; skip_i = 0; b1_i = 0; g1_i = 0; rd_hi_i = 0;
  endtask

  task automatic rd_check(string req);
    @(negedge clk); rd_hi_i = 1'b1;
    #1 check(req, rd_data_o, exp_cnt >> 8);
    exp_hold = exp_cnt & 255; exp_cnt = 0;
    @(negedge clk); rd_hi_i = 1'b0;
    #1 check("R6 held low byte", rd_data_o, exp_hold);
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (rst_ni && febe_vld_o) begin
      if (exp_q.size() == 0) check("R3 unexpected febe pulse", febe_o, -1);
      else check("R2 febe count", febe_o, exp_q.pop_front());
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; sync_i = 0; data_i = 0; data_vld_i = 0; sof_i = 0; skip_i = 0;
    b1_i = 0; g1_i = 0; rd_hi_i = 0;
    repeat (3) @(negedge clk);
    check("R8 yellow after reset", yellow_o, 0);
    check("R2 no febe after reset", febe_vld_o, 0);
    check("R6 hold after reset", rd_data_o, 0);
    rst_ni = 1;
    // R3: first frame after reset has no prior parity
    frame(1, 8'hFF, 8'h00, 0, 8'h5A);
    // R1 R2 R4: several error patterns
    frame(1, 8'h00, 8'h00, 0, 8'hA5);
    frame(1, 8'h01, 8'h10, 0, 8'h11);
    frame(1, 8'h81, 8'hF0, 0, 8'h00);
    frame(1, 8'hFF, 8'h07, 0, 8'hC3);
    frame(1, 8'h3C, 8'h00, 0, 8'h96);
    rd_check("R5 high byte after mixed errors");
    check("R4 accumulated total", exp_hold, 15);
    // R3: alignment loss suppresses the next comparison
    frame(0, 8'hFF, 8'h00, 0, 8'h21);
    frame(1, 8'hFF, 8'h00, 0, 8'h42);
    frame(1, 8'h0F, 8'h00, 0, 8'h84);
    rd_check("R3 count after realign");
    // R7: read on the B1 cycle keeps the new increment
    for (int i = 0; i < 40; i++) frame(1, 8'hFF, 8'h00, 0, 8'(i));
    frame(1, 8'h03, 8'h00, 1, 8'h77);
    @(negedge clk); #1 check("R7 held low byte", rd_data_o, exp_hold);
    rd_check("R7 count after coincident read");
    // R8: alarm rises after ten set frames
    for (int i = 0; i < 10; i++) begin
      frame(1, 8'h00, 8'h08, 0, 8'(i * 3));
      check("R8 yellow rising", yellow_o, exp_yel);
    end
    // R8 R9: other G1 bits ignored, break restarts the run
    for (int i = 0; i < 5; i++) begin
      frame(1, 8'h00, 8'hF7, 0, 8'(i));
      check("R9 yellow holding", yellow_o, exp_yel);
    end
    frame(1, 8'h00, 8'h08, 0, 8'h55);
    for (int i = 0; i < 10; i++) begin
      frame(1, 8'h00, 8'hF7, 0, 8'(i + 9));
      check("R9 yellow falling", yellow_o, exp_yel);
    end
    check("R9 yellow cleared", yellow_o, 0);
    // R4: saturation
    rd_check("R5 clear before saturation");
    for (int i = 0; i < 8200; i++) frame(1, 8'hFF, 8'h00, 0, 8'(i));
    rd_check("R4 saturated high byte");
    check("R4 saturated low byte", exp_hold, 255);
    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule